// File: doc/BRIEF.md
# Coefficient RAM Auto-Increment Loader

This block is the host-facing loader for the coefficient store of a programmable FIR filter. A host writes a small set of configuration registers over a narrow register bus. These registers hold the tap count, the mode bit that selects symmetric or asymmetric storage, and the first and last RAM addresses of a transfer window. The host then streams 20-bit coefficients through a single data register. Each coefficient is split across bus beats. The block collects the lower beats in a holding register and writes the complete word to RAM when the most significant beat arrives.

Reads and writes of the data register share one internal pointer. The pointer is loaded from the start address and steps by one per completed coefficient. When it reaches the stop address it stays there. Setting start equal to stop therefore gives access to exactly one RAM word, which is useful for debugging. A separate combinational read port lets the filter datapath fetch coefficients by address. The block also reports a coefficient offset that it computes from the tap count in symmetric mode, where only half of the coefficients are stored. The bus width is a parameter, and the number of beats per coefficient follows from it.

Top module: `coef_loader`

## Requirements
- R1: After reset, every configuration register, the pointer, the beat phase, the read data output and all RAM words are zero.
- R2: Register address 0 holds the tap count minus one. With control bit 0 at address 2 cleared (asymmetric mode), it reads back as at most 63. With the bit set (symmetric mode), it reads back the stored value, which can be up to 127.
- R3: Address 1 reads the coefficient offset. In asymmetric mode it is 0. In symmetric mode it is 64 - floor((taps+1)/2), where taps is the value held at address 0. Host writes to address 1 change nothing.
- R4: A write to address 3 (start) loads the pointer with the written value and returns the beat phase to the first beat. Address 4 holds the stop address.
- R5: On the 16-bit bus, the first write to address 5 gives coefficient bits 15:0 and the second gives bits 19:16. Only the second write stores the word in RAM at the pointer. A first beat on its own leaves the RAM unchanged.
- R6: After each stored or fully read coefficient, the pointer moves up by one. If it already equals the stop address, it stays there and does not wrap.
- R7: Reading address 5 returns bits 15:0 and then bits 19:16 of the RAM word at the pointer. Read data is registered and appears one cycle after the read strobe. The second beat advances the same pointer that writes use.
- R8: With start equal to stop, repeated coefficient writes all land in that single RAM word, and the neighbouring words are untouched.
- R9: The filter read port returns the RAM word at coef_raddr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe; wins over host_re |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 3 | Register select (0 taps, 1 offset, 2 control, 3 start, 4 stop, 5 data) |
| host_wdata | input | BUS_W | Write data |
| host_rdata | output | BUS_W | Registered read data |
| coef_raddr | input | AW | Filter-side RAM read address |
| coef_rdata | output | COEF_W | Filter-side RAM read data |

## Verification
The bench goes after the corners where the pointer and the beat phase can disagree with the host.

- A lone low beat must not reach RAM. A design that commits on every beat would corrupt the word there.
- Rewriting the start address must discard a half-written coefficient. If the phase is not cleared, the next low beat would be taken as a high beat.
- Extra writes past the stop address must pile onto the stop word. A wrapping or free-running pointer would scribble over the neighbouring word.
- Read-back must share the write pointer. Two full reads at the stop word must return it twice, and a read that fails to advance would return the first word again.
- Tap-count clamping and the computed symmetric offset are checked at both mode settings. A host write to the offset register must leave its value unchanged.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
   typedef enum logic [2:0] {
      REG_TAPS  = 3'd0,
      REG_OFFS  = 3'd1,
      REG_CTRL  = 3'd2,
      REG_START = 3'd3,
      REG_STOP  = 3'd4,
      REG_DATA  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/coef_cfg_regs.sv
module coef_cfg_regs
   import coef_loader_pkg::*;
#(
   parameter int AW       = 7,
   parameter int ASYM_MAX = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  reg_sel_e      sel,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] taps_eff,
   output logic [AW-1:0] offset,
   output logic          sym,
   output logic [AW-1:0] start_addr,
   output logic [AW-1:0] stop_addr
);
   localparam int            HALF     = 2 ** (AW - 1);
   localparam logic [AW-1:0] ASYM_LIM = AW'(ASYM_MAX - 1);

   logic [AW-1:0] taps_q;
   logic [AW-1:0] half;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taps_q     <= '0;
         sym        <= 1'b0;
         start_addr <= '0;
         stop_addr  <= '0;
      end else if (we) begin
         case (sel)
            REG_TAPS:  taps_q     <= wdata;
            REG_CTRL:  sym        <= wdata[0];
            REG_START: start_addr <= wdata;
            REG_STOP:  stop_addr  <= wdata;
            default:   ;
         endcase
      end
   end

   assign taps_eff = (!sym && (taps_q > ASYM_LIM)) ? ASYM_LIM : taps_q;
   assign half     = AW'((int'(taps_q) + 1) / 2);
   assign offset   = sym ? (AW'(HALF) - half) : '0;

   // R3
   offset_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == REG_OFFS) |=> $stable(offset));
endmodule

// File: rtl/coef_ptr.sv
module coef_ptr #(
   parameter int AW     = 7,
   parameter int NPARTS = 2,
   parameter int PW     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic [AW-1:0] stop_addr,
   input  logic          access,
   output logic [AW-1:0] ptr,
   output logic [PW-1:0] phase,
   output logic          commit
);
   localparam logic [PW-1:0] LAST = PW'(NPARTS - 1);

   assign commit = access && (phase == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr   <= '0;
         phase <= '0;
      end else if (load) begin
         ptr   <= load_val;
         phase <= '0;
      end else if (access) begin
         if (commit) begin
            phase <= '0;
            if (ptr != stop_addr) ptr <= ptr + 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   // R4
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ptr == $past(load_val)) && (phase == '0));
   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && commit && ptr != stop_addr) |=> ptr == $past(ptr) + 1'b1);
   // R6
   ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && commit && ptr == stop_addr) |=> $stable(ptr));
   // R5
   part_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && access && !commit) |=> $stable(ptr));
endmodule

// File: rtl/coef_assemble.sv
module coef_assemble #(
   parameter int COEF_W = 20,
   parameter int BUS_W  = 16,
   parameter int NPARTS = 2,
   parameter int PW     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [PW-1:0]     phase,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [COEF_W-1:0] ram_q,
   output logic [COEF_W-1:0] word,
   output logic [BUS_W-1:0]  rd_part
);
   localparam int LAST_LO = (NPARTS - 1) * BUS_W;

   generate
      if (NPARTS == 1) begin : g_direct
         assign word = wdata[COEF_W-1:0];
      end else begin : g_multi
         logic [LAST_LO-1:0] hold;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold <= '0;
            end else if (wr) begin
               for (int i = 0; i < LAST_LO; i++)
                  if ((i / BUS_W) == int'(phase)) hold[i] <= wdata[i % BUS_W];
            end
         end
         always_comb begin
            for (int i = 0; i < COEF_W; i++)
               word[i] = (i >= LAST_LO) ? wdata[i - LAST_LO] : hold[i];
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < BUS_W; i++) begin
         rd_part[i] = 1'b0;
         for (int k = 0; k < NPARTS; k++)
            if (int'(phase) == k && (k * BUS_W + i) < COEF_W)
               rd_part[i] = ram_q[k * BUS_W + i];
      end
   end
endmodule

// File: rtl/coef_ram.sv
module coef_ram #(
   parameter int COEF_W = 20,
   parameter int DEPTH  = 128,
   parameter int AW     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr_a,
   input  logic [COEF_W-1:0] wdata,
   output logic [COEF_W-1:0] q_a,
   input  logic [AW-1:0]     addr_b,
   output logic [COEF_W-1:0] q_b
);
   logic [COEF_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr_a] <= wdata;
      end
   end

   assign q_a = mem[addr_a];
   assign q_b = mem[addr_b];

   // R5
   ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(addr_a)] == $past(wdata));
endmodule

// File: rtl/coef_loader.sv
module coef_loader
   import coef_loader_pkg::*;
#(
   parameter int COEF_W   = 20,
   parameter int DEPTH    = 128,
   parameter int BUS_W    = 16,
   parameter int ASYM_MAX = 64,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_re,
   input  logic [2:0]        host_addr,
   input  logic [BUS_W-1:0]  host_wdata,
   output logic [BUS_W-1:0]  host_rdata,
   input  logic [AW-1:0]     coef_raddr,
   output logic [COEF_W-1:0] coef_rdata
);
   localparam int NPARTS = (COEF_W + BUS_W - 1) / BUS_W;
   localparam int PW     = (NPARTS > 1) ? $clog2(NPARTS) : 1;

   generate
      if (!(BUS_W == 8 || BUS_W == 16)) begin : g_bad_bus
         $error("coef_loader: BUS_W must be 8 or 16");
      end
      if (DEPTH != 2 ** AW || AW < 2 || AW > BUS_W) begin : g_bad_depth
         $error("coef_loader: DEPTH must be a power of two that fits the bus");
      end
      if (ASYM_MAX < 1 || ASYM_MAX > DEPTH) begin : g_bad_lim
         $error("coef_loader: ASYM_MAX out of range");
      end
   endgenerate

   reg_sel_e          sel;
   logic              data_wr, data_rd, start_we;
   logic [AW-1:0]     taps_eff, offset, start_addr, stop_addr, ptr;
   logic              sym, commit;
   logic [PW-1:0]     phase;
   logic [COEF_W-1:0] word, ram_q;
   logic [BUS_W-1:0]  rd_part, rd_next;

   assign sel      = reg_sel_e'(host_addr);
   assign data_wr  = host_we && sel == REG_DATA;
   assign data_rd  = host_re && !host_we && sel == REG_DATA;
   assign start_we = host_we && sel == REG_START;

   coef_cfg_regs #(.AW(AW), .ASYM_MAX(ASYM_MAX)) u_cfg (
      .clk, .rst_n, .we(host_we), .sel, .wdata(host_wdata[AW-1:0]),
      .taps_eff, .offset, .sym, .start_addr, .stop_addr
   );

   coef_ptr #(.AW(AW), .NPARTS(NPARTS), .PW(PW)) u_ptr (
      .clk, .rst_n, .load(start_we), .load_val(host_wdata[AW-1:0]),
      .stop_addr, .access(data_wr || data_rd), .ptr, .phase, .commit
   );

   coef_assemble #(.COEF_W(COEF_W), .BUS_W(BUS_W), .NPARTS(NPARTS), .PW(PW)) u_asm (
      .clk, .rst_n, .wr(data_wr), .phase, .wdata(host_wdata), .ram_q,
      .word, .rd_part
   );

   coef_ram #(.COEF_W(COEF_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk, .rst_n, .we(data_wr && commit), .addr_a(ptr), .wdata(word),
      .q_a(ram_q), .addr_b(coef_raddr), .q_b(coef_rdata)
   );

   always_comb begin
      case (sel)
         REG_TAPS:  rd_next = BUS_W'(taps_eff);
         REG_OFFS:  rd_next = BUS_W'(offset);
         REG_CTRL:  rd_next = BUS_W'(sym);
         REG_START: rd_next = BUS_W'(start_addr);
         REG_STOP:  rd_next = BUS_W'(stop_addr);
         REG_DATA:  rd_next = rd_part;
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  host_rdata <= '0;
      else if (host_re && !host_we) host_rdata <= rd_next;
   end

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_re |=> $stable(host_rdata));
endmodule

// File: tb/sim_coef_loader.sv
module sim_coef_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0, host_re = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [6:0]  coef_raddr = '0;
   logic [19:0] coef_rdata;
   int checks = 0, fails = 0, cyc = 0;
   bit done = 1'b0;

   coef_loader u0 (.*);

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk); host_re = 1'b1; host_addr = a;
      @(negedge clk); host_re = 1'b0; d = host_rdata;
   endtask

   task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      chk(req, 32'(d), 32'(exp));
   endtask

   task automatic peek(string req, logic [6:0] a, logic [19:0] exp);
      @(negedge clk); coef_raddr = a; #1;
      chk(req, 32'(coef_rdata), 32'(exp));
   endtask

   task automatic wcoef(logic [19:0] v);
      wr(3'd5, v[15:0]);
      wr(3'd5, {12'h000, v[19:16]});
   endtask

   task automatic t_reset;
      chk("R1 rdata", 32'(host_rdata), 0);
      rd_chk("R1 taps", 3'd0, 16'd0);
      rd_chk("R1 start", 3'd3, 16'd0);
      rd_chk("R1 stop", 3'd4, 16'd0);
      rd_chk("R1 ctrl", 3'd2, 16'd0);
      peek("R1 ram", 7'd0, 20'h0);
   endtask

   task automatic t_config;
      wr(3'd0, 16'd100);
      rd_chk("R2 clamp", 3'd0, 16'd63);
      wr(3'd2, 16'd1);
      rd_chk("R2 sym taps", 3'd0, 16'd100);
      rd_chk("R3 sym offset", 3'd1, 16'd14);
      wr(3'd1, 16'd5);
      rd_chk("R3 offset write ignored", 3'd1, 16'd14);
      wr(3'd0, 16'd127);
      rd_chk("R3 offset full", 3'd1, 16'd0);
      wr(3'd0, 16'd8);
      rd_chk("R3 offset nine taps", 3'd1, 16'd60);
      wr(3'd2, 16'd0);
      rd_chk("R3 asym offset", 3'd1, 16'd0);
      rd_chk("R2 asym small taps", 3'd0, 16'd8);
   endtask

   task automatic t_load;
      wr(3'd3, 16'd10);
      wr(3'd4, 16'd12);
      rd_chk("R4 start", 3'd3, 16'd10);
      rd_chk("R4 stop", 3'd4, 16'd12);
      wcoef(20'h12345); wcoef(20'hFEDCB); wcoef(20'h00F0F);
      peek("R6 word0", 7'd10, 20'h12345);
      peek("R6 word1", 7'd11, 20'hFEDCB);
      peek("R9 word2", 7'd12, 20'h00F0F);
      wcoef(20'h0BEEF); wcoef(20'h7C0DE);
      peek("R6 saturate", 7'd12, 20'h7C0DE);
      peek("R6 no overrun", 7'd13, 20'h0);
   endtask

   task automatic t_partial;
      wr(3'd3, 16'd20); wr(3'd4, 16'd20);
      wr(3'd5, 16'hABCD);
      peek("R5 low beat only", 7'd20, 20'h0);
      wr(3'd5, 16'h0005);
      peek("R5 commit", 7'd20, 20'h5ABCD);
   endtask

   task automatic t_phase_reset;
      wr(3'd4, 16'd31); wr(3'd3, 16'd30);
      wr(3'd5, 16'h1111);
      wr(3'd3, 16'd30);
      wr(3'd5, 16'h2222); wr(3'd5, 16'h0003);
      peek("R4 phase cleared", 7'd30, 20'h32222);
      peek("R4 next empty", 7'd31, 20'h0);
      wcoef(20'h44444);
      peek("R6 step", 7'd31, 20'h44444);
   endtask

   task automatic t_readback;
      wr(3'd4, 16'd12); wr(3'd3, 16'd10);
      rd_chk("R7 w0 lo", 3'd5, 16'h2345);
      rd_chk("R7 w0 hi", 3'd5, 16'h0001);
      rd_chk("R7 w1 lo", 3'd5, 16'hEDCB);
      rd_chk("R7 w1 hi", 3'd5, 16'h000F);
      rd_chk("R7 w2 lo", 3'd5, 16'hC0DE);
      rd_chk("R7 w2 hi", 3'd5, 16'h0007);
      rd_chk("R7 sat lo", 3'd5, 16'hC0DE);
      rd_chk("R7 sat hi", 3'd5, 16'h0007);
      peek("R7 read keeps ram", 7'd10, 20'h12345);
   endtask

   task automatic t_single;
      wr(3'd4, 16'd40); wr(3'd3, 16'd40);
      wcoef(20'h11111); wcoef(20'h22222);
      peek("R8 single", 7'd40, 20'h22222);
      peek("R8 above", 7'd41, 20'h0);
      peek("R8 below", 7'd39, 20'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config();
      t_load();
      t_partial();
      t_phase_reset();
      t_readback();
      t_single();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule